// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block translates 32-bit virtual addresses for a processor core. It holds a set of software-loaded translation entries that are all compared at once. Each entry is tagged with an address space identifier, so mappings that belong to different processes can stay resident across a context switch. The three top address bits pick the region first. Two kernel regions map straight onto physical memory, one cached and one uncached, and never consult the entries. The user region and the upper kernel region are translated through the entries.

A lookup is purely combinational. The core presents an address, the current identifier, the privilege mode and a load/store flag, and gets back exactly one outcome in the same cycle: a physical address with a cacheable flag, a miss, a modify fault or an address error. The block has no page-table walker. A miss is reported so that a software handler can load an entry through the indexed write port.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, so a translated-region lookup reports a miss.
- R2: A user-region access (address bit 31 = 0) that hits returns {entry frame number, address bits 11:0}.
- R3: A non-global entry matches only when its stored identifier equals the current identifier.
- R4: An entry with the global flag set matches under any identifier.
- R5: Addresses with top bits 100 bypass the entries and return {3'b000, address bits 28:0} with cacheable = 1, even when no entry exists.
- R6: Addresses with top bits 101 bypass the entries and return {3'b000, address bits 28:0} with cacheable = 0.
- R7: Addresses with top bits 11 are translated through the entries when in kernel mode.
- R8: A user-mode access with address bit 31 = 1 raises only the address error, whatever the entries hold.
- R9: A translated access with no valid matching entry raises the miss and returns physical address 0.
- R10: A store that hits an entry whose writable flag is 0 raises the modify fault. A load to that entry, or a store to a writable entry, translates normally.
- R11: On a translated hit the cacheable output is the inverse of the entry's no-cache flag. It is 0 on every outcome that is not a successful translation.
- R12: An indexed entry write takes effect at the next clock edge. A lookup in the same cycle as the write sees the previous contents.
- R13: When several entries match, the one with the lowest index supplies the translation.
- R14: Each access cycle asserts exactly one of ok, miss, modify fault and address error. An idle cycle asserts none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_i | input | 1 | Lookup request this cycle |
| store_i | input | 1 | Request is a store |
| user_i | input | 1 | Core is in user mode |
| va_i | input | 32 | Virtual address |
| asid_i | input | 6 | Current address space identifier |
| wr_en_i | input | 1 | Write an entry at the next edge |
| wr_idx_i | input | 6 | Entry index to write |
| wr_vpn_i | input | 20 | Virtual page number for the entry |
| wr_asid_i | input | 6 | Identifier for the entry |
| wr_pfn_i | input | 20 | Physical frame number for the entry |
| wr_valid_i | input | 1 | Entry valid flag |
| wr_dirty_i | input | 1 | Entry writable flag |
| wr_nc_i | input | 1 | Entry no-cache flag |
| wr_glb_i | input | 1 | Entry global flag |
| ok_o | output | 1 | Translation succeeded |
| pa_o | output | 32 | Physical address, 0 unless ok_o |
| cacheable_o | output | 1 | Access may be cached |
| miss_o | output | 1 | No matching entry |
| mod_fault_o | output | 1 | Store to a non-writable page |
| addr_err_o | output | 1 | User access to a kernel region |

## Verification
Entry state is visible only through lookups. A corrupted tag, identifier, flag or frame field therefore shows up on the first translated access that names that page, in the same cycle, as a wrong frame, a spurious miss or hit, or a wrong fault or cacheable flag. The bench keeps its own entry table and checks every cycle. It probes each written entry right after the write, and again in the write cycle itself, so a write that lands early, late or at the wrong index is caught within one cycle. Overlapping and global entries expose errors in the match and priority logic that single-entry tests would hide.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  typedef enum logic [1:0] {
    SEG_USER   = 2'd0,
    SEG_KDIR_C = 2'd1,
    SEG_KDIR_U = 2'd2,
    SEG_KMAP   = 2'd3
  } seg_e;

  typedef struct packed {
    logic valid;
    logic dirty;
    logic nocache;
    logic glb;
  } ent_flags_t;

  localparam int unsigned FLAGS_W = $bits(ent_flags_t);
endpackage

// File: rtl/asid_tlb_seg_dec.sv
module asid_tlb_seg_dec
  import asid_tlb_pkg::*;
#(
  parameter int unsigned VA_W = 32
) (
  input  logic [VA_W-1:0] va_i,
  output seg_e            seg_o
);
  logic [2:0] top;
  assign top = va_i[VA_W-1 -: 3];

  always_comb begin
    if (!top[2])           seg_o = SEG_USER;
    else if (top[1])       seg_o = SEG_KMAP;
    else if (top[0])       seg_o = SEG_KDIR_U;
    else                   seg_o = SEG_KDIR_C;
  end
endmodule

// File: rtl/asid_tlb_array.sv
module asid_tlb_array
  import asid_tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned ASID_W  = 6,
  parameter int unsigned PFN_W   = 20,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned PAY_W  = PFN_W + FLAGS_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic [VPN_W-1:0]               wr_vpn_i,
  input  logic [ASID_W-1:0]              wr_asid_i,
  input  logic [PFN_W-1:0]               wr_pfn_i,
  input  ent_flags_t                     wr_flags_i,
  input  logic [VPN_W-1:0]               lk_vpn_i,
  input  logic [ASID_W-1:0]              lk_asid_i,
  output logic [ENTRIES-1:0]             match_o,
  output logic [ENTRIES-1:0][PAY_W-1:0]  pay_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;
    logic [PFN_W-1:0]  pfn_q;
    ent_flags_t        flg_q;
    logic              sel;

    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vpn_q  <= '0;
        asid_q <= '0;
        pfn_q  <= '0;
        flg_q  <= '0;
      end else if (sel) begin
        vpn_q  <= wr_vpn_i;
        asid_q <= wr_asid_i;
        pfn_q  <= wr_pfn_i;
        flg_q  <= wr_flags_i;
      end
    end

    assign match_o[g] = flg_q.valid && (vpn_q == lk_vpn_i) &&
                        (flg_q.glb || (asid_q == lk_asid_i));
    assign pay_o[g]   = {pfn_q, flg_q};
  end
endmodule

// File: rtl/asid_tlb_pick.sv
module asid_tlb_pick #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned PAY_W   = 24
) (
  input  logic [ENTRIES-1:0]            match_i,
  input  logic [ENTRIES-1:0][PAY_W-1:0] pay_i,
  output logic                          hit_o,
  output logic [PAY_W-1:0]              pay_o
);
  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit_o = 1'b0;
    pay_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        hit_o = 1'b1;
        pay_o = pay_i[i];
      end
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned ASID_W  = 6,
  parameter int unsigned PFN_W   = 20,
  localparam int unsigned VPN_W  = VA_W - OFF_W,
  localparam int unsigned PA_W   = PFN_W + OFF_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned PAY_W  = PFN_W + FLAGS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              store_i,
  input  logic              user_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [PFN_W-1:0]  wr_pfn_i,
  input  logic              wr_valid_i,
  input  logic              wr_dirty_i,
  input  logic              wr_nc_i,
  input  logic              wr_glb_i,
  output logic              ok_o,
  output logic [PA_W-1:0]   pa_o,
  output logic              cacheable_o,
  output logic              miss_o,
  output logic              mod_fault_o,
  output logic              addr_err_o
);
  seg_e                            seg;
  ent_flags_t                      wr_flags, hit_flags;
  logic [ENTRIES-1:0]              match;
  logic [ENTRIES-1:0][PAY_W-1:0]   pay;
  logic                            hit;
  logic [PAY_W-1:0]                hit_pay;
  logic [PFN_W-1:0]                hit_pfn;
  logic [PA_W-1:0]                 pa_direct;

  assign wr_flags = '{valid: wr_valid_i, dirty: wr_dirty_i,
                      nocache: wr_nc_i, glb: wr_glb_i};

  asid_tlb_seg_dec #(.VA_W(VA_W)) u_seg (
    .va_i  (va_i),
    .seg_o (seg)
  );

  asid_tlb_array #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .ASID_W  (ASID_W),
    .PFN_W   (PFN_W)
  ) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_vpn_i   (wr_vpn_i),
    .wr_asid_i  (wr_asid_i),
    .wr_pfn_i   (wr_pfn_i),
    .wr_flags_i (wr_flags),
    .lk_vpn_i   (va_i[VA_W-1:OFF_W]),
    .lk_asid_i  (asid_i),
    .match_o    (match),
    .pay_o      (pay)
  );

  asid_tlb_pick #(.ENTRIES(ENTRIES), .PAY_W(PAY_W)) u_pick (
    .match_i (match),
    .pay_i   (pay),
    .hit_o   (hit),
    .pay_o   (hit_pay)
  );

  assign hit_pfn   = hit_pay[PAY_W-1:FLAGS_W];
  assign hit_flags = ent_flags_t'(hit_pay[FLAGS_W-1:0]);
  assign pa_direct = PA_W'(va_i[VA_W-4:0]);

  always_comb begin
    ok_o        = 1'b0;
    pa_o        = '0;
    cacheable_o = 1'b0;
    miss_o      = 1'b0;
    mod_fault_o = 1'b0;
    addr_err_o  = 1'b0;
    if (acc_i) begin
      if (user_i && seg != SEG_USER) begin
        addr_err_o = 1'b1;
      end else begin
        unique case (seg)
          SEG_KDIR_C, SEG_KDIR_U: begin
            ok_o        = 1'b1;
            pa_o        = pa_direct;
            cacheable_o = (seg == SEG_KDIR_C);
          end
          default: begin
            if (!hit) begin
              miss_o = 1'b1;
            end else if (store_i && !hit_flags.dirty) begin
              mod_fault_o = 1'b1;
            end else begin
              ok_o        = 1'b1;
              pa_o        = {hit_pfn, va_i[OFF_W-1:0]};
              cacheable_o = !hit_flags.nocache;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PA_W  = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            acc_i,
  input logic            store_i,
  input logic            user_i,
  input logic [VA_W-1:0] va_i,
  input logic            ok_o,
  input logic [PA_W-1:0] pa_o,
  input logic            cacheable_o,
  input logic            miss_o,
  input logic            mod_fault_o,
  input logic            addr_err_o
);
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |-> $countones({ok_o, miss_o, mod_fault_o, addr_err_o}) == 1); // R14

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |-> !(ok_o || miss_o || mod_fault_o || addr_err_o)); // R14

  AST_USER_KSEG_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && user_i && va_i[VA_W-1]) |-> addr_err_o); // R8

  AST_DIRECT_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o && va_i[VA_W-1 -: 2] == 2'b10) |-> pa_o == PA_W'(va_i[VA_W-4:0])); // R5

  AST_UNCACHED_SEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o && va_i[VA_W-1 -: 3] == 3'b101) |-> !cacheable_o); // R6

  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o && !va_i[VA_W-1]) |-> pa_o[OFF_W-1:0] == va_i[OFF_W-1:0]); // R2

  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (pa_o == '0 && !cacheable_o)); // R9

  AST_MOD_ON_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_fault_o |-> store_i); // R10

  AST_CACHE_NEEDS_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cacheable_o |-> ok_o); // R11
endmodule

bind asid_tlb asid_tlb_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_i       (acc_i),
  .store_i     (store_i),
  .user_i      (user_i),
  .va_i        (va_i),
  .ok_o        (ok_o),
  .pa_o        (pa_o),
  .cacheable_o (cacheable_o),
  .miss_o      (miss_o),
  .mod_fault_o (mod_fault_o),
  .addr_err_o  (addr_err_o)
);

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_i = 0, store_i = 0, user_i = 0;
  logic [31:0] va_i = '0;
  logic [5:0]  asid_i = '0;
  logic        wr_en_i = 0;
  logic [5:0]  wr_idx_i = '0;
  logic [19:0] wr_vpn_i = '0;
  logic [5:0]  wr_asid_i = '0;
  logic [19:0] wr_pfn_i = '0;
  logic        wr_valid_i = 0, wr_dirty_i = 0, wr_nc_i = 0, wr_glb_i = 0;
  logic        ok_o, cacheable_o, miss_o, mod_fault_o, addr_err_o;
  logic [31:0] pa_o;

  int checks = 0;
  int errors = 0;

  // reference table
  logic        m_v[64], m_d[64], m_nc[64], m_g[64];
  logic [19:0] m_vpn[64], m_pfn[64];
  logic [5:0]  m_asid[64];

  always #10 clk_i = ~clk_i;

  asid_tlb u_dut (
    .clk_i, .rst_ni, .acc_i, .store_i, .user_i, .va_i, .asid_i,
    .wr_en_i, .wr_idx_i, .wr_vpn_i, .wr_asid_i, .wr_pfn_i,
    .wr_valid_i, .wr_dirty_i, .wr_nc_i, .wr_glb_i,
    .ok_o, .pa_o, .cacheable_o, .miss_o, .mod_fault_o, .addr_err_o
  );

  // {ok, miss, mod, aerr, cacheable, pa}
  function automatic logic [36:0] expect_out();
    logic ok = 0, miss = 0, md = 0, ae = 0, ca = 0;
    logic [31:0] pa = '0;
    int found = -1;
    if (acc_i) begin
      if (user_i && va_i[31]) ae = 1;
      else if (va_i[31:30] == 2'b10) begin
        ok = 1; pa = {3'b000, va_i[28:0]}; ca = !va_i[29];
      end else begin
        for (int i = 0; i < 64; i++)
          if (found < 0 && m_v[i] && m_vpn[i] == va_i[31:12] &&
              (m_g[i] || m_asid[i] == asid_i)) found = i;
        if (found < 0) miss = 1;
        else if (store_i && !m_d[found]) md = 1;
        else begin
          ok = 1; pa = {m_pfn[found], va_i[11:0]}; ca = !m_nc[found];
        end
      end
    end
    return {ok, miss, md, ae, ca, pa};
  endfunction

  task automatic lookup(input string tag, input logic acc, input logic st,
                        input logic um, input logic [31:0] va, input logic [5:0] asid);
    logic [36:0] exp_v, act_v;
    acc_i = acc; store_i = st; user_i = um; va_i = va; asid_i = asid;
    #5;
    exp_v = expect_out();
    act_v = {ok_o, miss_o, mod_fault_o, addr_err_o, cacheable_o, pa_o};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s va=%h asid=%0d actual=%h expected=%h", tag, va, asid, act_v, exp_v);
    end
    @(posedge clk_i);
    if (wr_en_i) begin
      m_v[wr_idx_i] = wr_valid_i; m_d[wr_idx_i] = wr_dirty_i;
      m_nc[wr_idx_i] = wr_nc_i;   m_g[wr_idx_i] = wr_glb_i;
      m_vpn[wr_idx_i] = wr_vpn_i; m_pfn[wr_idx_i] = wr_pfn_i;
      m_asid[wr_idx_i] = wr_asid_i;
    end
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic set_wr(input int idx, input logic [19:0] vpn, input logic [5:0] asid,
                        input logic [19:0] pfn, input logic v, input logic d,
                        input logic nc, input logic g);
    wr_en_i = 1; wr_idx_i = 6'(idx); wr_vpn_i = vpn; wr_asid_i = asid;
    wr_pfn_i = pfn; wr_valid_i = v; wr_dirty_i = d; wr_nc_i = nc; wr_glb_i = g;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      m_v[i] = 0; m_d[i] = 0; m_nc[i] = 0; m_g[i] = 0;
      m_vpn[i] = '0; m_pfn[i] = '0; m_asid[i] = '0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    lookup("R14 idle", 0, 0, 0, 32'h0001_2345, 6'd3);
    lookup("R1 reset miss", 1, 0, 0, 32'h0000_0000, 6'd0);
    lookup("R1 reset miss kmap", 1, 0, 0, 32'hC000_0000, 6'd0);

    // R12: lookup in the write cycle sees the old (empty) entry
    set_wr(5, 20'h00012, 6'd3, 20'hABCDE, 1, 1, 0, 0);
    lookup("R12 same cycle", 1, 0, 0, 32'h0001_2345, 6'd3);
    lookup("R2 R12 next cycle", 1, 0, 0, 32'h0001_2345, 6'd3);
    lookup("R2 offset", 1, 0, 1, 32'h0001_2FFF, 6'd3);
    lookup("R3 other asid", 1, 0, 0, 32'h0001_2345, 6'd4);
    lookup("R10 store writable", 1, 1, 1, 32'h0001_2000, 6'd3);

    set_wr(9, 20'h00040, 6'd1, 20'h11111, 1, 0, 1, 1);
    lookup("R12 write cycle", 1, 0, 1, 32'h0004_0ABC, 6'd7);
    lookup("R4 global", 1, 0, 1, 32'h0004_0ABC, 6'd7);
    lookup("R11 nocache", 1, 0, 0, 32'h0004_0001, 6'd63);
    lookup("R10 mod fault", 1, 1, 1, 32'h0004_0ABC, 6'd7);

    lookup("R5 kdir cached", 1, 0, 0, 32'h8000_1234, 6'd0);
    lookup("R5 kdir top", 1, 1, 0, 32'h9FFF_FFFF, 6'd5);
    lookup("R6 kdir uncached", 1, 0, 0, 32'hA0AB_CDEF, 6'd0);
    lookup("R6 kdir uncached end", 1, 0, 0, 32'hBFFF_F000, 6'd2);

    lookup("R8 user kdir", 1, 0, 1, 32'h8000_1234, 6'd3);
    lookup("R8 user kmap", 1, 1, 1, 32'hC000_0ABC, 6'd3);

    set_wr(63, 20'hC0000, 6'd3, 20'h00077, 1, 1, 0, 0);
    lookup("R9 kmap miss before", 1, 0, 0, 32'hC000_0ABC, 6'd3);
    lookup("R7 kmap hit", 1, 0, 0, 32'hC000_0ABC, 6'd3);
    lookup("R8 user kmap mapped", 1, 0, 1, 32'hC000_0ABC, 6'd3);
    lookup("R9 kmap miss", 1, 0, 0, 32'hE000_0000, 6'd3);

    set_wr(2, 20'h00012, 6'd3, 20'h22222, 1, 1, 1, 0);
    lookup("R12 dup pending", 1, 0, 0, 32'h0001_2345, 6'd3);
    lookup("R13 lowest index", 1, 0, 0, 32'h0001_2345, 6'd3);
    set_wr(2, 20'h00012, 6'd3, 20'h22222, 0, 1, 1, 0);
    lookup("R12 invalidate pending", 1, 0, 0, 32'h0001_2345, 6'd3);
    lookup("R13 back to higher", 1, 0, 0, 32'h0001_2345, 6'd3);

    for (int i = 10; i < 30; i++) begin
      set_wr(i, 20'(i * 7 + 1), 6'(i), 20'(i * 1000), 1, i[0], i[1], 0);
      lookup("R12 fill", 1, i[0], 1, {20'(i * 7 + 1), 12'h5A5}, 6'(i));
      lookup("R2 fill hit", 1, i[0], 1, {20'(i * 7 + 1), 12'h5A5}, 6'(i));
      lookup("R10 fill store", 1, 1, 0, {20'(i * 7 + 1), 12'h010}, 6'(i));
      lookup("R3 fill asid", 1, 0, 1, {20'(i * 7 + 1), 12'h010}, 6'(i + 1));
    end

    rst_ni = 0;
    #1;
    for (int i = 0; i < 64; i++) m_v[i] = 0;
    @(negedge clk_i);
    rst_ni = 1;
    lookup("R1 miss after reset", 1, 0, 0, 32'h0001_2345, 6'd3);
    lookup("R1 global gone", 1, 0, 0, 32'h0004_0ABC, 6'd7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule